// File: doc/BRIEF.md
# Dual-Output Serial Flash Read Controller

This block is the host side of a read from a serial NOR flash. A single start pulse carries a start address, a byte count, an address-width select and a latency select. The controller pulls chip select low and clocks out an 8-bit read opcode followed by the address on IO0, one bit per serial clock. It then waits a programmable number of latency clocks and collects read data two bits per serial clock on IO1 and IO0.

The flash advances its own address after every byte, so one command streams any number of consecutive bytes. The flash also wraps from its top address back to zero with no help from the host. Every assembled byte is handed to the user with a one-cycle strobe. When the last byte has arrived, chip select is raised and a done pulse follows.

The serial clock runs at half the system clock: it is low for one system cycle and high for the next. The opcode depends on the address width: 3Bh with 24 address bits, 3Ch with 32 address bits. IO0 is a split pin (`io0_out`, `io0_oe`, `io0_in`) so that it can be resolved into a bidirectional pad outside the block.

Top module: `spi_dual_reader`

## Requirements
- R1: After reset, `cs_n` is 1, while `sck`, `io0_oe`, `rd_valid`, `done` and `busy` are all 0.
- R2: With `addr4_sel`=0 the controller sends opcode 8'h3B followed by `start_addr[23:0]`. With `addr4_sel`=1 it sends opcode 8'h3C followed by `start_addr[31:0]`. Bits go out most significant first, one per SCK cycle on `io0_out`, with `io0_oe`=1 and values changing only while SCK is low.
- R3: After the last address bit, the controller inserts 8 SCK cycles of latency when `dummy_en`=1 and none when `dummy_en`=0. `io0_oe` is 0 from the first latency cycle, or from the first data cycle when there is no latency, until the next request.
- R4: Data is sampled on the SCK rising edge. Within each byte, `io1_in` carries bits 7, 5, 3, 1 and `io0_in` carries bits 6, 4, 2, 0, in that order, so each byte takes 4 SCK cycles.
- R5: A request returns exactly `byte_count` bytes, in order, from consecutive flash addresses, using one opcode and one address per request, including when the flash wraps from its top address to 0.
- R6: `rd_valid` is high for exactly one system cycle per byte, with `rd_byte` valid in that cycle, and only while `cs_n` is 0.
- R7: SCK is low whenever `cs_n` is 1. `cs_n` falls at least one system cycle before the first SCK rising edge, and it returns to 1 after the last byte's final SCK cycle.
- R8: `done` pulses high for one cycle, one cycle after `cs_n` returns to 1. `busy` is 1 from the cycle after an accepted start until `done`.
- R9: A `start` pulse while `busy` is 1 is ignored: the running transfer, its address and its length are unaffected, and no second transfer follows.
- R10: A `start` pulse with `byte_count`=0 is ignored: `cs_n` stays 1, `busy` stays 0 and no `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, sampled while idle |
| start_addr | input | 32 | First flash byte address |
| byte_count | input | LEN_W | Number of bytes to read |
| addr4_sel | input | 1 | 1: 32-bit address with opcode 3Ch; 0: 24-bit address with opcode 3Bh |
| dummy_en | input | 1 | 1: insert DUMMY_CYC latency clocks |
| busy | output | 1 | Transfer in progress |
| rd_byte | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe for rd_byte |
| done | output | 1 | One-cycle end-of-transfer pulse |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock, idles low |
| io0_out | output | 1 | IO0 output value |
| io0_oe | output | 1 | IO0 output enable |
| io0_in | input | 1 | IO0 input value |
| io1_in | input | 1 | IO1 input value |

## Verification
A wrong phase counter or wrong latency state shows up at the ports within one byte time. The opcode or address check in the responder fails at the first wrong header bit. A shift of even one SCK cycle in the latency count misaligns every bit pair, so the first `rd_byte` after the header is wrong. A wrong bit order in the byte assembler corrupts the first strobed byte. A wrong remaining-byte counter shows only at the end of the frame, as an extra or missing strobe before `done`. A busy guard that lets a second start through shows as a changed address or byte count, or as a second `done`, within a few hundred cycles.

// File: rtl/spi_dr_pkg.sv
// Shared types and constants for the dual-output flash read controller.
package spi_dr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_CMD,
        ST_DUMMY,
        ST_DATA,
        ST_TRAIL
    } rd_state_t;

    localparam logic [7:0] OPC_ADDR24 = 8'h3B;
    localparam logic [7:0] OPC_ADDR32 = 8'h3C;
    localparam int         OPC_BITS   = 8;
    localparam int         PAIRS_PER_BYTE = 4;
endpackage

// File: rtl/spi_dr_cmdshift.sv
// Header shifter: holds opcode and address left-aligned and presents the
// most significant bit. Assumes the caller asserts shift once per SCK
// falling transition and load only while idle.
module spi_dr_cmdshift #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    output logic         bit_out
);
    logic [W-1:0] sr;

    // Load the header word or advance it by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_word;
        end else if (shift) begin
            sr <= {sr[W-2:0], 1'b0};
        end
    end

    assign bit_out = sr[W-1];
endmodule

// File: rtl/spi_dr_pairpack.sv
// Byte assembler for two-line reads: each sample takes IO1 as the higher
// and IO0 as the lower bit of a pair, most significant pair first.
// Assumes sample is high for one cycle per SCK rising edge in the data phase.
module spi_dr_pairpack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       sample,
    input  logic       io0,
    input  logic       io1,
    output logic [7:0] byte_out,
    output logic       byte_stb
);
    import spi_dr_pkg::*;
    localparam int PW = $clog2(PAIRS_PER_BYTE);
    localparam logic [PW-1:0] LAST_PAIR = PW'(PAIRS_PER_BYTE - 1);

    logic [5:0]    sr;
    logic [PW-1:0] pair;

    // Shift in bit pairs and emit a strobed byte after the fourth pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr       <= '0;
            pair     <= '0;
            byte_out <= '0;
            byte_stb <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            if (clear) begin
                pair <= '0;
            end else if (sample) begin
                sr   <= {sr[3:0], io1, io0};
                pair <= pair + 1'b1;
                if (pair == LAST_PAIR) begin
                    byte_out <= {sr, io1, io0};
                    byte_stb <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_dual_reader.sv
// Host controller for a dual-output flash read: single-line header, optional
// latency, then two-line data. SCK is the system clock divided by two, idle
// low. Assumes DUMMY_CYC >= 1 and start_addr is 32 bits wide.
module spi_dual_reader #(
    parameter int LEN_W     = 16,
    parameter int DUMMY_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      start_addr,
    input  logic [LEN_W-1:0] byte_count,
    input  logic             addr4_sel,
    input  logic             dummy_en,
    output logic             busy,
    output logic [7:0]       rd_byte,
    output logic             rd_valid,
    output logic             done,
    output logic             cs_n,
    output logic             sck,
    output logic             io0_out,
    output logic             io0_oe,
    input  logic             io0_in,
    input  logic             io1_in
);
    import spi_dr_pkg::*;

    localparam int HDR_W   = OPC_BITS + 32;
    localparam int HDR3_W  = OPC_BITS + 24;
    localparam int CNT_MAX = (HDR_W > DUMMY_CYC) ? HDR_W : DUMMY_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    rd_state_t        st;
    logic             sck_q;
    logic             cs_n_q;
    logic             done_q;
    logic             dummy_q;
    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] left;
    logic             go;
    logic             fall;
    logic [HDR_W-1:0] hdr_word;
    logic             hdr_bit;

    assign go   = (st == ST_IDLE) && start && (byte_count != '0);
    assign fall = sck_q && (st == ST_CMD || st == ST_DUMMY || st == ST_DATA);

    // Header image: opcode, then address, left-aligned.
    always_comb begin
        if (addr4_sel) hdr_word = {OPC_ADDR32, start_addr};
        else           hdr_word = {OPC_ADDR24, start_addr[23:0], 8'h00};
    end

    // Sequence the frame: lead-in, header, latency, data, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            sck_q   <= 1'b0;
            cs_n_q  <= 1'b1;
            done_q  <= 1'b0;
            dummy_q <= 1'b0;
            cnt     <= '0;
            left    <= '0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (go) begin
                        st      <= ST_LEAD;
                        cs_n_q  <= 1'b0;
                        left    <= byte_count;
                        dummy_q <= dummy_en;
                        cnt     <= addr4_sel ? CNT_W'(HDR_W) : CNT_W'(HDR3_W);
                    end
                end
                ST_LEAD: st <= ST_CMD;
                ST_CMD, ST_DUMMY, ST_DATA: begin
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                    end else begin
                        sck_q <= 1'b0;
                        if (cnt == CNT_W'(1)) begin
                            if (st == ST_CMD && dummy_q) begin
                                st  <= ST_DUMMY;
                                cnt <= CNT_W'(DUMMY_CYC);
                            end else if (st != ST_DATA) begin
                                st  <= ST_DATA;
                                cnt <= CNT_W'(PAIRS_PER_BYTE);
                            end else if (left == LEN_W'(1)) begin
                                st     <= ST_TRAIL;
                                cs_n_q <= 1'b1;
                            end else begin
                                left <= left - 1'b1;
                                cnt  <= CNT_W'(PAIRS_PER_BYTE);
                            end
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                ST_TRAIL: begin
                    done_q <= 1'b1;
                    st     <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    spi_dr_cmdshift #(.W(HDR_W)) u_hdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (go),
        .load_word (hdr_word),
        .shift     (fall && st == ST_CMD),
        .bit_out   (hdr_bit)
    );

    spi_dr_pairpack u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (go),
        .sample   (st == ST_DATA && !sck_q),
        .io0      (io0_in),
        .io1      (io1_in),
        .byte_out (rd_byte),
        .byte_stb (rd_valid)
    );

    assign io0_oe  = (st == ST_LEAD) || (st == ST_CMD);
    assign io0_out = io0_oe & hdr_bit;
    assign sck     = sck_q;
    assign cs_n    = cs_n_q;
    assign done    = done_q;
    assign busy    = (st != ST_IDLE);
endmodule

// File: rtl/spi_dr_checker.sv
// Protocol checker for spi_dual_reader: framing of SCK, IO0 drive, strobes
// and done against chip select. Assumes the synchronous active-low reset.
module spi_dr_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic io0_oe,
    input logic rd_valid,
    input logic done,
    input logic busy
);
    assert_sck_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);
    assert_lead_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |=> !sck);
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> cs_n);
    assert_oe_framed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        io0_oe |-> !cs_n);
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    assert_valid_framed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !cs_n);
    assert_done_after_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !busy && $past(cs_n)));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind spi_dual_reader spi_dr_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck      (sck),
    .io0_oe   (io0_oe),
    .rd_valid (rd_valid),
    .done     (done),
    .busy     (busy)
);

// File: tb/sim_spi_dual_reader.sv
// Bench for spi_dual_reader with a behavioural flash responder.
module sim_spi_dual_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [15:0] byte_count = '0;
    logic        addr4_sel = 1'b0;
    logic        dummy_en = 1'b0;
    logic        busy, rd_valid, done, cs_n, sck, io0_out, io0_oe;
    logic [7:0]  rd_byte;
    logic        fl_io0 = 1'b0, fl_io1 = 1'b0, fl_drive = 1'b0;
    logic        io0_bus;

    int n_checks = 0, n_fail = 0;

    always #4 clk = ~clk;

    assign io0_bus = io0_oe ? io0_out : fl_io0;

    spi_dual_reader u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .addr4_sel(addr4_sel), .dummy_en(dummy_en),
        .busy(busy), .rd_byte(rd_byte), .rd_valid(rd_valid), .done(done),
        .cs_n(cs_n), .sck(sck), .io0_out(io0_out), .io0_oe(io0_oe),
        .io0_in(io0_bus), .io1_in(fl_io1)
    );

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ {a[20:16], a[23:21]} ^ a[31:24] ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected configuration of the current request.
    logic        m_a4 = 1'b0;
    logic        m_dum = 1'b0;
    logic [31:0] m_addr = '0;
    int          m_hdr = 32, m_lat = 0;
    logic [31:0] m_mask = 32'h00FF_FFFF;

    // Flash responder: receives header, checks it, serves data.
    int          rises = 0;
    logic [7:0]  f_op = '0;
    logic [31:0] f_addr = '0;
    always @(negedge cs_n) begin
        rises = 0; f_op = '0; f_addr = '0;
    end
    always @(posedge cs_n) fl_drive = 1'b0;
    always @(posedge sck) if (!cs_n) begin
        if (rises < 8) f_op = {f_op[6:0], io0_bus};
        else if (rises < m_hdr) f_addr = {f_addr[30:0], io0_bus};
        if (rises >= m_hdr) chk(!io0_oe, "R3 io0_oe in latency/data", io0_oe, 0);
        if (io0_oe && fl_drive) chk(0, "R3 contention", 1, 0);
        rises++;
        if (rises == 8) chk(f_op == (m_a4 ? 8'h3C : 8'h3B), "R2 opcode", f_op, m_a4 ? 8'h3C : 8'h3B);
        if (rises == m_hdr) chk(f_addr == (m_addr & m_mask), "R2 address", f_addr, m_addr & m_mask);
    end
    always @(negedge sck) if (!cs_n && rises >= m_hdr + m_lat) begin
        int p, k;
        logic [7:0] b;
        p = rises - m_hdr - m_lat;
        k = p % 4;
        b = pat((f_addr + 32'(p / 4)) & m_mask);
        fl_io1 = b[7 - 2*k];
        fl_io0 = b[6 - 2*k];
        fl_drive = 1'b1;
    end

    // Output monitor, sampled away from the active edge.
    int idx = 0, n_done = 0, lead = 0;
    bit seen_rise = 0;
    always @(negedge clk) if (rst_n) begin
        if (rd_valid) begin
            logic [7:0] e;
            e = pat((m_addr + 32'(idx)) & m_mask);
            chk(rd_byte == e, "R4/R5 data byte", rd_byte, e);
            idx++;
        end
        if (done) n_done++;
        if (!cs_n && !sck && !seen_rise) lead++;
        if (sck) seen_rise = 1;
    end

    // Watchdog.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic issue(input logic a4, input logic den, input logic [31:0] ad, input logic [15:0] n);
        @(negedge clk);
        start = 1'b1; addr4_sel = a4; dummy_en = den; start_addr = ad; byte_count = n;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_req(input logic a4, input logic den, input logic [31:0] ad, input logic [15:0] n);
        int d0;
        m_a4 = a4; m_dum = den; m_addr = ad;
        m_hdr = a4 ? 40 : 32; m_lat = den ? 8 : 0;
        m_mask = a4 ? 32'hFFFF_FFFF : 32'h00FF_FFFF;
        idx = 0; lead = 0; seen_rise = 0;
        d0 = n_done;
        issue(a4, den, ad, n);
        for (int t = 0; t < 20000 && n_done == d0; t++) @(negedge clk);
        chk(n_done == d0 + 1, "R8 done seen", n_done - d0, 1);
        chk(idx == int'(n), "R5 byte count", idx, n);
        chk(lead >= 1, "R7 cs lead", lead, 1);
        chk(cs_n && !sck && !busy, "R7 released", {cs_n, sck, busy}, 3'b100);
        repeat (4) @(negedge clk);
        chk(n_done == d0 + 1, "R8 single done", n_done - d0, 1);
    endtask

    // Stimulus table: {addr4_sel, dummy_en, start_addr, byte_count}.
    localparam int NV = 6;
    localparam logic [49:0] VEC [NV] = '{
        {1'b0, 1'b1, 32'h0000_0100, 16'd3},
        {1'b1, 1'b1, 32'h1234_5678, 16'd2},
        {1'b0, 1'b0, 32'h00FF_FFFE, 16'd4},
        {1'b1, 1'b0, 32'hFFFF_FFFF, 16'd2},
        {1'b0, 1'b1, 32'hAB00_00C3, 16'd1},
        {1'b1, 1'b1, 32'h8000_0000, 16'd5}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(cs_n === 1'b1, "R1 cs_n", cs_n, 1);
        chk({sck, io0_oe, rd_valid, done, busy} === 5'b0, "R1 outputs",
            {sck, io0_oe, rd_valid, done, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            run_req(VEC[v][49], VEC[v][48], VEC[v][47:16], VEC[v][15:0]);
        end
        // R9: start while busy is ignored.
        begin
            int d0;
            m_a4 = 0; m_dum = 1; m_addr = 32'h0000_0200; m_hdr = 32; m_lat = 8;
            m_mask = 32'h00FF_FFFF; idx = 0; lead = 0; seen_rise = 0;
            d0 = n_done;
            issue(1'b0, 1'b1, 32'h0000_0200, 16'd3);
            repeat (20) @(negedge clk);
            chk(busy, "R8 busy during transfer", busy, 1);
            issue(1'b1, 1'b0, 32'h0000_F000, 16'd5);
            for (int t = 0; t < 20000 && n_done == d0; t++) @(negedge clk);
            repeat (20) @(negedge clk);
            chk(idx == 3, "R9 length kept", idx, 3);
            chk(n_done == d0 + 1, "R9 no second transfer", n_done - d0, 1);
            chk(cs_n && !busy, "R9 idle after", {cs_n, busy}, 2'b10);
        end
        // R10: zero-length request is ignored.
        begin
            int d0;
            d0 = n_done; idx = 0;
            issue(1'b0, 1'b0, 32'h0000_0010, 16'd0);
            for (int t = 0; t < 10; t++) begin
                @(negedge clk);
                chk(cs_n && !busy, "R10 stays idle", {cs_n, busy}, 2'b10);
            end
            chk(n_done == d0 && idx == 0, "R10 no done or data", n_done - d0, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule